// File: doc/BRIEF.md
# Indexed Interrupt Redirection Controller

This block routes numbered interrupt lines to a single delivery port. Each line owns one 64-bit redirection entry. The entry holds the vector to send, a delivery mode, a destination mode, a destination, a mask bit and two status bits that software cannot change. Software reaches every register through two byte offsets. It writes a register index into the select register at offset 0x00, then reads or writes the chosen 32-bit word through the data window at offset 0x10. Index 0x00 is an identification word, 0x01 a read-only version word and 0x02 an arbitration word. From index 0x10 upward the indices cover the table, two per entry.

A raised line is checked against its entry's mask at the moment it arrives. An unmasked raise is kept in a pending latch. Pending lines are handed one at a time to a registered output stage, lowest line number first. The output stage presents a snapshot of the entry's fields under a valid/ready handshake. Masked raises are dropped. Line numbers outside the table are refused and flagged.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: A write to offset 0x00 stores the low 8 bits of the data as the select index, and a read of offset 0x00 returns that index zero-extended. The index resets to 0. Read data is registered: it appears after the clock edge that samples the read and holds until the next read.
- R2: Index 0x00 (identification) and index 0x02 (arbitration) each store only bits 27:24 of written data. All their other bits read as zero, and both reset to zero.
- R3: Index 0x01 reads {8'h00, NUM_LINES-1, 8'h00, VERSION}, which is 0x00170011 with the defaults. A window write to it changes nothing and pulses bus_err.
- R4: Index 0x10+2n addresses bits 31:0 of entry n and index 0x10+2n+1 addresses bits 63:32. After reset every low half reads 0x00010000 (mask bit 16 set) and every high half reads 0.
- R5: A write to a low half takes every bit from the data except bit 12 (delivery status) and bit 14 (remote IRR), which keep their value. Both are zero from reset, so writing 0xFFFFFFFF reads back as 0xFFFFAFFF.
- R6: Indices 0x03 to 0x0F and indices from 0x10+2*NUM_LINES upward read as zero and ignore window writes. Any window access to them pulses bus_err for one cycle, in the same cycle the registered read data appears.
- R7: Accesses to offsets other than 0x00 and 0x10 read zero, change no register and raise no error.
- R8: Raising a line whose entry has bit 16 clear delivers the line number and the entry's fields: vector (bits 7:0), delivery mode (bits 10:8), destination mode (bit 11) and destination (bits 63:56).
- R9: Raising a line whose mask bit is set delivers nothing. The mask is sampled when the raise arrives, so clearing the mask later does not bring the raise back.
- R10: A raise with a line number at or above NUM_LINES delivers nothing and pulses raise_err in the following cycle. Raises of valid lines never pulse raise_err.
- R11: Pending lines are served lowest number first. A raise of a line that is already pending is merged with it and produces a single delivery.
- R12: dlv_valid and the delivered fields hold steady until dlv_ready is high at a clock edge. Each accepted handshake removes exactly one delivery. With the output idle, dlv_valid rises after the second clock edge following the raise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write when high |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a refused or out-of-range window access |
| raise_valid | input | 1 | An interrupt line is raised this cycle |
| raise_line | input | 8 | Number of the raised line |
| raise_err | output | 1 | One-cycle pulse after a raise of a line outside the table |
| dlv_valid | output | 1 | A delivery is offered |
| dlv_ready | input | 1 | Consumer accepts the offered delivery |
| dlv_line | output | 8 | Line number of the delivery |
| dlv_vector | output | 8 | Vector from the entry |
| dlv_mode | output | 3 | Delivery mode from the entry |
| dlv_dest_mode | output | 1 | Destination mode from the entry |
| dlv_dest | output | 8 | Destination from the entry |

## Verification
The bench builds the block with NUM_LINES set to 4. Every one of the 256 select values can then be swept through the window three times: once at reset, once with a write pattern derived from the index, and once on readback. That covers the identification, version and arbitration words, all eight table halves, the boundary at index 0x18 and every invalid index. With four lines, every line can also be raised, including the first out-of-range number, 4. One pending set then shows lowest-first order, merging and the mask being sampled at raise time.

// File: rtl/irc_pkg.sv
package irc_pkg;

    localparam logic [7:0]  OFF_SEL  = 8'h00;
    localparam logic [7:0]  OFF_WIN  = 8'h10;
    localparam logic [7:0]  IDX_ID   = 8'h00;
    localparam logic [7:0]  IDX_VER  = 8'h01;
    localparam logic [7:0]  IDX_ARB  = 8'h02;
    localparam logic [7:0]  IDX_TBL  = 8'h10;
    localparam logic [31:0] LO_KEEP  = 32'h0000_5000;
    localparam logic [31:0] NIB_MASK = 32'h0F00_0000;

    typedef struct packed {
        logic [7:0]  dest;
        logic [38:0] rsvd;
        logic        mask;
        logic        trig;
        logic        rirr;
        logic        pol;
        logic        dstat;
        logic        dst_mode;
        logic [2:0]  dlv_mode;
        logic [7:0]  vector;
    } rte_t;

    typedef enum logic [2:0] {
        ACC_ID,
        ACC_VER,
        ACC_ARB,
        ACC_LO,
        ACC_HI,
        ACC_BAD
    } acc_kind_t;

    typedef struct packed {
        logic [7:0] line;
        logic [7:0] vector;
        logic [2:0] mode;
        logic       dest_mode;
        logic [7:0] dest;
    } dlv_t;

    function automatic rte_t rte_reset();
        rte_t e;
        e = '0;
        e.mask = 1'b1;
        return e;
    endfunction

    function automatic acc_kind_t decode_sel(input logic [7:0] sel, input int n);
        int off;
        off = int'(sel) - int'(IDX_TBL);
        if (sel == IDX_ID)  return ACC_ID;
        if (sel == IDX_VER) return ACC_VER;
        if (sel == IDX_ARB) return ACC_ARB;
        if (off >= 0 && off < 2 * n) return sel[0] ? ACC_HI : ACC_LO;
        return ACC_BAD;
    endfunction

    function automatic logic [6:0] ent_of(input logic [7:0] sel);
        logic [7:0] d;
        d = sel - IDX_TBL;
        return d[7:1];
    endfunction

    function automatic logic [31:0] ver_word(input int n, input logic [7:0] ver);
        return {8'h00, 8'(n - 1), 8'h00, ver};
    endfunction

endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
    import irc_pkg::*;
#(
    parameter int         N       = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output rte_t [N-1:0]      entries_o
);

    logic [7:0]  sel_q;
    logic [3:0]  id_q;
    logic [3:0]  arb_q;
    rte_t        tbl_q [N];
    acc_kind_t   kind;
    logic [6:0]  ent;
    logic        sel_hit;
    logic        win_hit;
    logic        win_wr;
    logic [31:0] win_val;
    logic [31:0] rd_val;
    logic        err_d;
    logic [31:0] rdata_q;
    logic        err_q;
    logic [N-1:0] prot_any;

    assign sel_hit = bus_en && (bus_addr == OFF_SEL);
    assign win_hit = bus_en && (bus_addr == OFF_WIN);
    assign win_wr  = win_hit && bus_we;
    assign kind    = decode_sel(sel_q, N);
    assign ent     = ent_of(sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
            arb_q <= '0;
        end else begin
            if (sel_hit && bus_we) sel_q <= bus_wdata[7:0];
            if (win_wr && kind == ACC_ID)  id_q  <= bus_wdata[27:24];
            if (win_wr && kind == ACC_ARB) arb_q <= bus_wdata[27:24];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                tbl_q[g] <= rte_reset();
            end else if (win_wr && ent == 7'(g)) begin
                if (kind == ACC_LO)
                    tbl_q[g][31:0] <= (bus_wdata & ~LO_KEEP) | (tbl_q[g][31:0] & LO_KEEP);
                else if (kind == ACC_HI)
                    tbl_q[g][63:32] <= bus_wdata;
            end
        end
        assign entries_o[g] = tbl_q[g];
    end

    always_comb begin
        win_val = '0;
        case (kind)
            ACC_ID:  win_val = {4'h0, id_q, 24'h0};
            ACC_VER: win_val = ver_word(N, VERSION);
            ACC_ARB: win_val = {4'h0, arb_q, 24'h0};
            ACC_LO, ACC_HI: begin
                for (int i = 0; i < N; i++)
                    if (ent == 7'(i))
                        win_val = (kind == ACC_LO) ? tbl_q[i][31:0] : tbl_q[i][63:32];
            end
            default: win_val = '0;
        endcase
    end

    always_comb begin
        if (sel_hit)      rd_val = {24'h0, sel_q};
        else if (win_hit) rd_val = win_val;
        else              rd_val = '0;
        err_d = win_hit && ((kind == ACC_BAD) || (kind == ACC_VER && bus_we));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (bus_en && !bus_we) rdata_q <= rd_val;
            err_q <= err_d;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

    always_comb begin
        for (int i = 0; i < N; i++)
            prot_any[i] = tbl_q[i].rirr | tbl_q[i].dstat;
    end

    // R3: a version write is refused and flagged
    a_r3_ver_refused: assert property (@(posedge clk) disable iff (rst)
        (win_wr && sel_q == IDX_VER) |=> bus_err);

    // R6: a write to an unassigned index leaves the table alone
    a_r6_bad_write_inert: assert property (@(posedge clk) disable iff (rst)
        (win_wr && kind == ACC_BAD) |=> ($stable(entries_o) && bus_err));

    // R5: software writes never move the protected status bits
    a_r5_status_untouched: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we) |=> $stable(prot_any));

    // R7: accesses off the two offsets raise no error
    a_r7_other_offset_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !sel_hit && !win_hit) |=> !bus_err);

endmodule

// File: rtl/irc_prio.sv
module irc_prio #(
    parameter int N  = 24,
    parameter int LW = 5
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [LW-1:0] idx,
    output logic          any
);

    assign grant = req & ((~req) + {{(N-1){1'b0}}, 1'b1});
    assign any   = |req;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (req[i]) idx = LW'(i);
    end

endmodule

// File: rtl/irc_dispatch.sv
module irc_dispatch
    import irc_pkg::*;
#(
    parameter int N  = 24,
    parameter int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raise_valid,
    input  logic [7:0]    raise_line,
    input  rte_t [N-1:0]  entries,
    input  logic          dlv_ready,
    output logic          dlv_valid,
    output dlv_t          dlv_o,
    output logic          raise_err
);

    logic [N-1:0]  pending_q;
    logic [N-1:0]  set_vec;
    logic [N-1:0]  clr_vec;
    logic [N-1:0]  grant;
    logic [LW-1:0] grant_idx;
    logic          any_req;
    logic          load;
    logic          in_range;
    logic          line_masked;
    logic [LW-1:0] raise_idx;
    logic          out_valid_q;
    dlv_t          out_q;
    logic          err_q;

    assign in_range  = int'(raise_line) < N;
    assign raise_idx = raise_line[LW-1:0];

    always_comb begin
        set_vec     = '0;
        line_masked = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (raise_line == 8'(i)) begin
                line_masked = entries[i].mask;
                set_vec[i]  = raise_valid && !entries[i].mask;
            end
        end
    end

    irc_prio #(.N(N), .LW(LW)) u_prio (
        .req   (pending_q),
        .grant (grant),
        .idx   (grant_idx),
        .any   (any_req)
    );

    assign load    = any_req && (!out_valid_q || dlv_ready);
    assign clr_vec = load ? grant : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q   <= '0;
            out_valid_q <= 1'b0;
            out_q       <= '0;
            err_q       <= 1'b0;
        end else begin
            pending_q <= (pending_q & ~clr_vec) | set_vec;
            err_q     <= raise_valid && !in_range;
            if (load) begin
                out_valid_q     <= 1'b1;
                out_q.line      <= 8'(grant_idx);
                out_q.vector    <= entries[grant_idx].vector;
                out_q.mode      <= entries[grant_idx].dlv_mode;
                out_q.dest_mode <= entries[grant_idx].dst_mode;
                out_q.dest      <= entries[grant_idx].dest;
            end else if (dlv_ready) begin
                out_valid_q <= 1'b0;
            end
        end
    end

    assign dlv_valid = out_valid_q;
    assign dlv_o     = out_q;
    assign raise_err = err_q;

    // R8: an unmasked raise lands in the pending latch
    a_r8_unmasked_pends: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && in_range && !line_masked) |=> pending_q[$past(raise_idx)]);

    // R9: a masked raise leaves its line idle
    a_r9_masked_dropped: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && in_range && line_masked && !pending_q[raise_idx])
        |=> !pending_q[$past(raise_idx)]);

    // R10: out-of-range line numbers are flagged
    a_r10_range_flag: assert property (@(posedge clk) disable iff (rst)
        (raise_valid && !in_range) |=> raise_err);

    // R11: the grant is a single pending line with nothing lower pending
    a_r11_lowest_first: assert property (@(posedge clk) disable iff (rst)
        any_req |-> ($onehot(grant) && ((grant & pending_q) == grant)
                     && (((grant - {{(N-1){1'b0}}, 1'b1}) & pending_q) == '0)));

    // R12: an offer holds until accepted
    a_r12_offer_holds: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_o)));

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
    import irc_pkg::*;
#(
    parameter int         NUM_LINES = 24,
    parameter logic [7:0] VERSION   = 8'h11
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    input  logic        raise_valid,
    input  logic [7:0]  raise_line,
    output logic        raise_err,
    output logic        dlv_valid,
    input  logic        dlv_ready,
    output logic [7:0]  dlv_line,
    output logic [7:0]  dlv_vector,
    output logic [2:0]  dlv_mode,
    output logic        dlv_dest_mode,
    output logic [7:0]  dlv_dest
);

    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    rte_t [NUM_LINES-1:0] entries;
    dlv_t                 dlv;

    irc_regfile #(.N(NUM_LINES), .VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .entries_o (entries)
    );

    irc_dispatch #(.N(NUM_LINES), .LW(LINE_W)) u_disp (
        .clk         (clk),
        .rst         (rst),
        .raise_valid (raise_valid),
        .raise_line  (raise_line),
        .entries     (entries),
        .dlv_ready   (dlv_ready),
        .dlv_valid   (dlv_valid),
        .dlv_o       (dlv),
        .raise_err   (raise_err)
    );

    assign dlv_line      = dlv.line;
    assign dlv_vector    = dlv.vector;
    assign dlv_mode      = dlv.mode;
    assign dlv_dest_mode = dlv.dest_mode;
    assign dlv_dest      = dlv.dest;

endmodule

// File: tb/irq_redirect_ctrl_test.sv
module irq_redirect_ctrl_test;

    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        raise_valid = 1'b0;
    logic [7:0]  raise_line = '0;
    logic        raise_err;
    logic        dlv_valid;
    logic        dlv_ready = 1'b0;
    logic [7:0]  dlv_line, dlv_vector, dlv_dest;
    logic [2:0]  dlv_mode;
    logic        dlv_dest_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_lo [NL];
    logic [31:0] m_hi [NL];
    logic [31:0] m_id, m_arb;

    always #5 clk = ~clk;

    irq_redirect_ctrl #(.NUM_LINES(NL)) uut (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .raise_valid(raise_valid), .raise_line(raise_line), .raise_err(raise_err),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_line(dlv_line),
        .dlv_vector(dlv_vector), .dlv_mode(dlv_mode),
        .dlv_dest_mode(dlv_dest_mode), .dlv_dest(dlv_dest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic er);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata; er = bus_err;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic raise(input logic [7:0] ln, output logic er);
        @(negedge clk);
        raise_valid = 1'b1; raise_line = ln;
        @(negedge clk);
        er = raise_err;
        raise_valid = 1'b0;
    endtask

    function automatic logic [31:0] pat(input logic [7:0] i);
        return {i, ~i, i ^ 8'h5A, 8'hC3};
    endfunction

    function automatic bit bad_idx(input int i);
        return (i >= 3 && i < 16) || (i >= 16 + 2 * NL);
    endfunction

    function automatic logic [31:0] model_rd(input int i);
        if (i == 0) return m_id;
        if (i == 1) return {8'h00, 8'(NL - 1), 8'h00, 8'h11};
        if (i == 2) return m_arb;
        if (bad_idx(i)) return 32'h0;
        if (i[0]) return m_hi[(i - 16) / 2];
        return m_lo[(i - 16) / 2];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog act=running exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        logic [7:0]  got_line [8];
        logic [7:0]  got_vec [8];
        int          cnt;

        m_id = '0; m_arb = '0;
        for (int e = 0; e < NL; e++) begin m_lo[e] = 32'h0001_0000; m_hi[e] = '0; end

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        acc(1'b0, 8'h00, '0, rd, er);
        chk("R1 select reset", rd, 32'h0);
        chk("R12 idle after reset", {31'h0, dlv_valid}, 32'h0);

        // Sweep 1: reset values of every index
        for (int i = 0; i < 256; i++) begin
            acc(1'b1, 8'h00, 32'hFFFF_FF00 | 32'(i), rd, er);
            acc(1'b0, 8'h00, '0, rd, er);
            chk("R1 select readback", rd, 32'(i));
            acc(1'b0, 8'h10, '0, rd, er);
            chk("R4 R3 R6 reset read", rd, model_rd(i));
            chk("R6 read err", {31'h0, er}, {31'h0, bad_idx(i)});
        end

        // Sweep 2: write a pattern through every index
        for (int i = 0; i < 256; i++) begin
            acc(1'b1, 8'h00, 32'(i), rd, er);
            acc(1'b1, 8'h10, pat(8'(i)), rd, er);
            chk("R3 R6 write err", {31'h0, er}, {31'h0, (i == 1) || bad_idx(i)});
            if (i == 0) m_id = pat(8'(i)) & 32'h0F00_0000;
            else if (i == 2) m_arb = pat(8'(i)) & 32'h0F00_0000;
            else if (!bad_idx(i) && i >= 16) begin
                if (i % 2 == 1) m_hi[(i - 16) / 2] = pat(8'(i));
                else m_lo[(i - 16) / 2] = (pat(8'(i)) & ~32'h5000) | (m_lo[(i - 16) / 2] & 32'h5000);
            end
        end

        // Sweep 3: read back every index
        for (int i = 0; i < 256; i++) begin
            acc(1'b1, 8'h00, 32'(i), rd, er);
            acc(1'b0, 8'h10, '0, rd, er);
            chk("R2 R4 R5 R6 readback", rd, model_rd(i));
        end

        // R5: all-ones low half keeps bits 12 and 14 clear
        acc(1'b1, 8'h00, 32'h12, rd, er);
        acc(1'b1, 8'h10, 32'hFFFF_FFFF, rd, er);
        acc(1'b0, 8'h10, '0, rd, er);
        chk("R5 protected bits", rd, 32'hFFFF_AFFF);

        // R7: other offsets are inert
        acc(1'b1, 8'h04, 32'hFFFF_FFFF, rd, er);
        chk("R7 write err", {31'h0, er}, 32'h0);
        acc(1'b1, 8'h14, 32'h0000_0000, rd, er);
        acc(1'b1, 8'hFF, 32'h0000_0000, rd, er);
        acc(1'b0, 8'h14, '0, rd, er);
        chk("R7 read zero", rd, 32'h0);
        chk("R7 read err", {31'h0, er}, 32'h0);
        acc(1'b0, 8'h00, '0, rd, er);
        chk("R7 select kept", rd, 32'h12);
        acc(1'b0, 8'h10, '0, rd, er);
        chk("R7 window kept", rd, 32'hFFFF_AFFF);

        // Program entries: line n vector 0x40+n, mode n, dest mode n[0], dest 0x80+n; line 3 masked
        for (int n = 0; n < NL; n++) begin
            acc(1'b1, 8'h00, 32'(16 + 2 * n), rd, er);
            acc(1'b1, 8'h10, ((n == 3) ? 32'h0001_0000 : 32'h0) | (32'(n) << 8)
                             | (32'(n % 2) << 11) | 32'(8'h40 + 8'(n)), rd, er);
            acc(1'b1, 8'h00, 32'(17 + 2 * n), rd, er);
            acc(1'b1, 8'h10, {8'(8'h80 + 8'(n)), 24'h0}, rd, er);
        end

        // R11: pending set with ready low
        raise(8'd2, er); chk("R10 valid no err", {31'h0, er}, 32'h0);
        raise(8'd1, er);
        raise(8'd0, er);
        raise(8'd1, er);
        raise(8'd3, er); chk("R10 masked no err", {31'h0, er}, 32'h0);
        raise(8'd5, er); chk("R10 out of range err", {31'h0, er}, 32'h1);
        raise(8'd4, er); chk("R10 boundary line err", {31'h0, er}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R12 offer valid", {31'h0, dlv_valid}, 32'h1);
        chk("R8 line", {24'h0, dlv_line}, 32'd2);
        chk("R8 vector", {24'h0, dlv_vector}, 32'h42);
        chk("R8 mode", {29'h0, dlv_mode}, 32'd2);
        chk("R8 dest mode", {31'h0, dlv_dest_mode}, 32'd0);
        chk("R8 dest", {24'h0, dlv_dest}, 32'h82);

        cnt = 0;
        dlv_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (dlv_valid) begin
                got_line[cnt] = dlv_line;
                got_vec[cnt]  = dlv_vector;
                cnt++;
            end
            @(negedge clk);
        end
        dlv_ready = 1'b0;
        chk("R11 R9 R10 delivery count merged", 32'(cnt), 32'd3);
        chk("R11 order first", {24'h0, got_line[0]}, 32'd2);
        chk("R11 order second", {24'h0, got_line[1]}, 32'd0);
        chk("R11 order third", {24'h0, got_line[2]}, 32'd1);
        chk("R8 vector second", {24'h0, got_vec[1]}, 32'h40);
        chk("R8 vector third", {24'h0, got_vec[2]}, 32'h41);

        // R9: unmask line 3 later; the earlier raise stays dropped
        acc(1'b1, 8'h00, 32'h16, rd, er);
        acc(1'b1, 8'h10, 32'h0000_0B43, rd, er);
        repeat (3) @(negedge clk);
        chk("R9 no late delivery", {31'h0, dlv_valid}, 32'h0);

        // R12: latency and single delivery per handshake
        dlv_ready = 1'b1;
        raise(8'd3, er);
        chk("R12 not after first edge", {31'h0, dlv_valid}, 32'h0);
        @(negedge clk);
        chk("R12 valid after second edge", {31'h0, dlv_valid}, 32'h1);
        chk("R8 line 3", {24'h0, dlv_line}, 32'd3);
        chk("R8 mode 3", {29'h0, dlv_mode}, 32'd3);
        chk("R8 dest mode 3", {31'h0, dlv_dest_mode}, 32'd1);
        chk("R8 dest 3", {24'h0, dlv_dest}, 32'h83);
        @(negedge clk);
        chk("R12 one per handshake", {31'h0, dlv_valid}, 32'h0);
        dlv_ready = 1'b0;

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule